// File: doc/BRIEF.md
# CEC Receive Address Filter and Acknowledge Decision

This block sits behind the bit-level receiver of a CEC bus node. It sees every byte on the line, one strobe per byte. The first byte of each message is the header. The block splits the header into the sender (initiator) address and the target (destination) address. It then decides two things for that message and for every later byte of it:

- whether the byte is passed upward as accepted;
- whether the bit-timing layer should pull the acknowledge bit low.

The node's own identity is a mask. Each set bit claims one logical address, so one node can answer to several addresses at once.

The block has two listen modes:

- **Reduced listen:** the node takes only traffic aimed at one of its own addresses, plus broadcasts.
- **Full listen:** the node also takes other nodes' traffic, but stays silent on the acknowledge bit for it.

The block also enforces the length limit of a message: 16 bytes, header included. When the node is itself the transmitter, the block watches the sampled acknowledge and flags a directed byte that no follower confirmed.

The byte input is a plain strobe with no back-pressure. The block takes a byte in every cycle in which `byte_vld` is high, and the producer may present a byte in any cycle. Every output is registered and is valid one clock after the strobe. The per-byte outputs are single-cycle pulses. The per-message outputs are levels that hold until the next header.

Top module: `cec_rx_addr_filter`

## Requirements
- R1: When the destination d (header bits 3:0) is below 15 and `own_mask[d]` is 1, each byte of the message, header included, gives `byte_accept`=1 and `ack_drive`=1. This holds for d=14 (mask bit 14) as well.
- R2: When several mask bits are set, a header to any of those addresses is accepted and acknowledged.
- R3: In reduced listen mode (`full_listen`=0), a message to an address that is not claimed and is not 15 gives `byte_accept`=0 and `ack_drive`=0.
- R4: Destination 15 is broadcast. It sets `bcast`=1 and is accepted in both listen modes, but never gives `ack_drive`=1, even when all 15 mask bits are set.
- R5: In full listen mode, a message to an address that is not claimed is accepted with `ack_drive`=0. A claimed address is still acknowledged.
- R6: `init_addr` takes header bits 7:4 and `dest_addr` takes header bits 3:0. Both hold unchanged through the payload bytes of that message.
- R7: A header strobed with `byte_last`=1 is a complete ping. The next strobed byte is decoded as a new header.
- R8: Up to 16 bytes, header included, are accepted. The 17th byte of an accepted message gives `ovf_err`=1 for one cycle, `byte_accept`=0, `ack_drive`=0 and `msg_accept`=0. The later bytes of that message are not accepted and do not repeat `ovf_err`.
- R9: Bytes strobed with `tx_mode`=1 at the header are never accepted or acknowledged. In such a message, a byte with `ack_in`=0 and a destination other than 15 gives `tx_ack_err`=1. A byte with `ack_in`=1, or any byte of a broadcast, gives `tx_ack_err`=0.
- R10: After reset, every output is 0.
- R11: The outputs follow a strobe by one clock. In a cycle after no strobe, `byte_accept`, `ack_drive`, `ovf_err` and `tx_ack_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_mask | input | 15 | Claimed logical addresses, one bit per address 0..14 |
| full_listen | input | 1 | 1 = also take traffic for other nodes, without acknowledge |
| tx_mode | input | 1 | The message being strobed is the node's own transmission (sampled at the header) |
| byte_vld | input | 1 | One received byte is present this cycle |
| byte_data | input | 8 | Byte value; for a header, initiator in 7:4 and destination in 3:0 |
| byte_last | input | 1 | This byte ends the message |
| ack_in | input | 1 | Acknowledge seen on the bus for this byte (1 = confirmed) |
| byte_accept | output | 1 | Pulse: the byte belongs to an accepted message |
| ack_drive | output | 1 | Pulse: drive a positive acknowledge for this byte |
| msg_accept | output | 1 | Level: the current message is accepted and has not overflowed |
| bcast | output | 1 | Level: the current message is a broadcast |
| init_addr | output | 4 | Level: initiator of the current message |
| dest_addr | output | 4 | Level: destination of the current message |
| ovf_err | output | 1 | Pulse: the message went past 16 bytes |
| tx_ack_err | output | 1 | Pulse: a directed byte of the node's own transmission was not acknowledged |

## Verification
The block keeps two pieces of state: the latched header decision and the byte counter.

A header decision latched wrongly shows in the cycle after the very next payload strobe. `byte_accept`, `ack_drive` or the held addresses then disagree with the header sent.

A counter that drifts shows when a message crosses the 16-byte limit. The overflow pulse can come one byte early or late, and acceptance can fail to recover on the next header. The bench sends full-length, over-length and ping messages back to back so that both kinds of fault appear within one message.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } hdr_t;
endpackage

// File: rtl/cec_addr_match.sv
module cec_addr_match #(
  parameter int ADDR_W = 4,
  localparam int NUM_ADDR = 1 << ADDR_W,
  localparam int MASK_W = NUM_ADDR - 1
) (
  input  logic [MASK_W-1:0] own_mask,
  input  logic [ADDR_W-1:0] dst,
  input  logic              full_listen,
  input  logic              tx_mode,
  output logic              is_own,
  output logic              is_bcast,
  output logic              take
);
  localparam logic [ADDR_W-1:0] BCAST = ADDR_W'(NUM_ADDR - 1);

  logic [MASK_W-1:0] hit;

  // One comparator per claimable address; the mask gates each slot.
  for (genvar g = 0; g < MASK_W; g++) begin : g_slot
    assign hit[g] = own_mask[g] && (dst == ADDR_W'(g));
  end

  assign is_own   = |hit;
  assign is_bcast = (dst == BCAST);
  assign take     = !tx_mode && (is_own || is_bcast || full_listen);
endmodule

// File: rtl/cec_len_track.sv
module cec_len_track #(
  parameter int MAX_BYTES = 16,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic byte_last,
  output logic at_header,
  output logic at_limit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);

  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (byte_vld) begin
      if (byte_last)
        idx_q <= '0;
      else if (idx_q != LIMIT)
        idx_q <= idx_q + 1'b1;
    end
  end

  assign at_header = (idx_q == '0);
  assign at_limit  = (idx_q == LIMIT);
endmodule

// File: rtl/cec_rx_addr_filter.sv
module cec_rx_addr_filter
  import cec_filt_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  localparam int MASK_W = (1 << ADDR_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] own_mask,
  input  logic              full_listen,
  input  logic              tx_mode,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  input  logic              ack_in,
  output logic              byte_accept,
  output logic              ack_drive,
  output logic              msg_accept,
  output logic              bcast,
  output logic [ADDR_W-1:0] init_addr,
  output logic [ADDR_W-1:0] dest_addr,
  output logic              ovf_err,
  output logic              tx_ack_err
);
  hdr_t hdr;
  logic at_header, at_limit;
  logic m_own, m_bc, m_take;
  logic take_q, own_q, bc_q, tx_q, drop_q;
  logic cur_take, cur_own, cur_bc, cur_tx, cur_drop, live;

  assign hdr = hdr_t'(byte_data);

  cec_len_track #(.MAX_BYTES(MAX_BYTES)) i_len (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_last(byte_last),
    .at_header(at_header), .at_limit(at_limit)
  );

  cec_addr_match #(.ADDR_W(ADDR_W)) i_match (
    .own_mask(own_mask), .dst(hdr.dst), .full_listen(full_listen),
    .tx_mode(tx_mode), .is_own(m_own), .is_bcast(m_bc), .take(m_take)
  );

  // Header decides on live inputs; payload bytes reuse the latched decision.
  always_comb begin
    cur_take = at_header ? m_take  : take_q;
    cur_own  = at_header ? m_own   : own_q;
    cur_bc   = at_header ? m_bc    : bc_q;
    cur_tx   = at_header ? tx_mode : tx_q;
    cur_drop = at_header ? 1'b0    : drop_q;
    live     = cur_take && !cur_drop && !at_limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_accept <= 1'b0;
      ack_drive   <= 1'b0;
      ovf_err     <= 1'b0;
      tx_ack_err  <= 1'b0;
      msg_accept  <= 1'b0;
      take_q      <= 1'b0;
      own_q       <= 1'b0;
      bc_q        <= 1'b0;
      tx_q        <= 1'b0;
      drop_q      <= 1'b0;
      init_addr   <= '0;
      dest_addr   <= '0;
    end else begin
      byte_accept <= 1'b0;
      ack_drive   <= 1'b0;
      ovf_err     <= 1'b0;
      tx_ack_err  <= 1'b0;
      if (byte_vld) begin
        byte_accept <= live;
        ack_drive   <= live && cur_own && !cur_bc;
        ovf_err     <= at_limit && cur_take && !cur_drop;
        tx_ack_err  <= cur_tx && !cur_bc && !ack_in;
        msg_accept  <= cur_take && !(cur_drop || at_limit);
        drop_q      <= byte_last ? 1'b0 : (cur_drop || at_limit);
        if (at_header) begin
          take_q    <= m_take;
          own_q     <= m_own;
          bc_q      <= m_bc;
          tx_q      <= tx_mode;
          init_addr <= hdr.src;
          dest_addr <= hdr.dst;
        end
      end
    end
  end

  assign bcast = bc_q;
endmodule

// File: rtl/cec_rx_addr_filter_chk.sv
module cec_rx_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic byte_accept,
  input logic ack_drive,
  input logic msg_accept,
  input logic bcast,
  input logic ovf_err,
  input logic tx_ack_err
);
  AST_ACK_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> byte_accept); // R1

  AST_BCAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> !bcast); // R4

  AST_OVF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (!byte_accept && !ack_drive && !msg_accept)); // R8

  AST_TXERR_NOT_RX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack_err |-> (!byte_accept && !ack_drive)); // R9

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !(byte_accept || ack_drive || ovf_err || tx_ack_err)); // R11
endmodule

bind cec_rx_addr_filter cec_rx_addr_filter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_accept(byte_accept),
  .ack_drive(ack_drive), .msg_accept(msg_accept), .bcast(bcast),
  .ovf_err(ovf_err), .tx_ack_err(tx_ack_err)
);

// File: tb/test_cec_rx_addr_filter.sv
`timescale 1ns/1ps
module test_cec_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] own_mask = '0;
  logic        full_listen = 1'b0;
  logic        tx_mode = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_last = 1'b0;
  logic        ack_in = 1'b0;
  logic        byte_accept, ack_drive, msg_accept, bcast, ovf_err, tx_ack_err;
  logic [3:0]  init_addr, dest_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cec_rx_addr_filter i_cec_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .own_mask(own_mask), .full_listen(full_listen),
    .tx_mode(tx_mode), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_last(byte_last), .ack_in(ack_in), .byte_accept(byte_accept),
    .ack_drive(ack_drive), .msg_accept(msg_accept), .bcast(bcast),
    .init_addr(init_addr), .dest_addr(dest_addr), .ovf_err(ovf_err),
    .tx_ack_err(tx_ack_err)
  );

  // Vector fields: mask[29:15] full[14] tx[13] ack[12] hdr[11:4] exp{acc,ackd,bc,txe}[3:0]
  localparam int NV = 13;
  localparam logic [29:0] VEC [NV] = '{
    {15'h0010, 1'b0, 1'b0, 1'b0, 8'h34, 4'b1100},  // R1 own address 4
    {15'h0010, 1'b0, 1'b0, 1'b0, 8'h35, 4'b0000},  // R3 other address, reduced
    {15'h0120, 1'b0, 1'b0, 1'b0, 8'h08, 4'b1100},  // R2 mask 5 and 8, dest 8
    {15'h0120, 1'b0, 1'b0, 1'b0, 8'h15, 4'b1100},  // R2 dest 5
    {15'h0000, 1'b0, 1'b0, 1'b0, 8'h4F, 4'b1010},  // R4 broadcast, reduced
    {15'h0000, 1'b1, 1'b0, 1'b0, 8'h4F, 4'b1010},  // R4 broadcast, full
    {15'h0010, 1'b1, 1'b0, 1'b0, 8'h27, 4'b1000},  // R5 other address, full
    {15'h0010, 1'b1, 1'b0, 1'b0, 8'h24, 4'b1100},  // R5 own address, full
    {15'h0000, 1'b0, 1'b1, 1'b0, 8'h03, 4'b0001},  // R9 tx, no ack
    {15'h0000, 1'b0, 1'b1, 1'b1, 8'h03, 4'b0000},  // R9 tx, acked
    {15'h0000, 1'b0, 1'b1, 1'b0, 8'h0F, 4'b0010},  // R9 tx broadcast
    {15'h4000, 1'b0, 1'b0, 1'b0, 8'h1E, 4'b1100},  // R1 top address 14
    {15'h7FFF, 1'b0, 1'b0, 1'b0, 8'hAF, 4'b1010}   // R4 full mask, broadcast
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic last, input logic tx,
                      input logic ack);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = d; byte_last = last; tx_mode = tx; ack_in = ack;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  function automatic logic [3:0] pulses();
    return {byte_accept, ack_drive, bcast, tx_ack_err};
  endfunction

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({byte_accept, ack_drive, msg_accept, bcast, ovf_err, tx_ack_err,
           init_addr, dest_addr} == '0, "R10 reset outputs",
          {byte_accept, ack_drive, msg_accept, bcast, ovf_err, tx_ack_err}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      own_mask = VEC[i][29:15];
      full_listen = VEC[i][14];
      send(VEC[i][11:4], 1'b1, VEC[i][13], VEC[i][12]);
      check(pulses() == VEC[i][3:0], $sformatf("R1..R9 vector %0d", i),
            pulses(), VEC[i][3:0]);
      check({init_addr, dest_addr} == VEC[i][11:4], "R6 header decode",
            {init_addr, dest_addr}, VEC[i][11:4]);
    end

    // R11: idle cycle clears pulses
    @(negedge clk);
    check({byte_accept, ack_drive, ovf_err, tx_ack_err} == 4'b0, "R11 idle",
          {byte_accept, ack_drive, ovf_err, tx_ack_err}, 0);

    // R6/R8: 16-byte message fully accepted, addresses held
    own_mask = 15'h0010; full_listen = 1'b0;
    send(8'h34, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k < 16; k++) begin
      send(8'(k * 7), k == 15, 1'b0, 1'b0);
      check(byte_accept && ack_drive && !ovf_err && msg_accept,
            $sformatf("R8 byte %0d within limit", k),
            {byte_accept, ack_drive, ovf_err, msg_accept}, 4'b1101);
      check({init_addr, dest_addr} == 8'h34, "R6 held over payload",
            {init_addr, dest_addr}, 8'h34);
    end

    // R8: 17-byte message overflows
    send(8'h34, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k < 16; k++) send(8'h55, 1'b0, 1'b0, 1'b0);
    send(8'h66, 1'b0, 1'b0, 1'b0);
    check({byte_accept, ack_drive, msg_accept, ovf_err} == 4'b0001, "R8 17th byte",
          {byte_accept, ack_drive, msg_accept, ovf_err}, 4'b0001);
    send(8'h77, 1'b1, 1'b0, 1'b0);
    check({byte_accept, ack_drive, msg_accept, ovf_err} == 4'b0000, "R8 after overflow",
          {byte_accept, ack_drive, msg_accept, ovf_err}, 4'b0000);
    send(8'h24, 1'b1, 1'b0, 1'b0);
    check(byte_accept && ack_drive && msg_accept, "R8 recovery on next header",
          {byte_accept, ack_drive, msg_accept}, 3'b111);

    // R7: ping then a new header is decoded afresh
    send(8'h34, 1'b1, 1'b0, 1'b0);
    send(8'h95, 1'b1, 1'b0, 1'b0);
    check({init_addr, dest_addr} == 8'h95 && !byte_accept, "R7 new header after ping",
          {init_addr, dest_addr, byte_accept}, {8'h95, 1'b0});

    // R9: own transmission, payload byte missing acknowledge
    send(8'h03, 1'b0, 1'b1, 1'b1);
    check(!tx_ack_err && !byte_accept, "R9 tx header acked",
          {tx_ack_err, byte_accept}, 0);
    send(8'h44, 1'b1, 1'b0, 1'b0);
    check(tx_ack_err && !byte_accept && !ack_drive, "R9 tx payload unacked",
          {tx_ack_err, byte_accept, ack_drive}, 3'b100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule